// File: doc/BRIEF.md
# Converter Fault and Soft-Start Supervisor

This block is the digital sequencer that sits beside a current-mode switching converter controller. It keeps the controller in reset until a start request arrives. It then ramps a soft-start code from zero to full scale, and that code caps the peak-current command passed on to the analog loop. It also gates the power switch cycle by cycle.

Two fault paths restart the converter, and they behave differently. An average-current overcurrent flag holds the controller in reset for as long as the flag stays high. An error amplifier that stays pinned at its maximum for a programmed number of oscillator periods is treated as an output short. In that case the block fires a single-cycle reset and restarts. After either fault, soft start runs again from zero.

Within each switching period the switch turns on at the oscillator tick. It turns off at the PWM comparator trip or at the 75 % duty limit, whichever comes first. A period is skipped entirely when the clamped peak-current command is below a programmable floor.

Top module: `dcdc_supervisor`

## Requirements
- R1: While `rst_n` is low, and afterwards while `start_req` is low, `ctl_rst` is 1, `ss_code` is 0 and `sw_drive` is 0, whatever the ticks.
- R2: With `start_req` high and `ovc_flag` low, `ctl_rst` falls at the first clock edge, and `ss_code` starts at 0.
- R3: While active, each `osc_tick` advances the ramp. After k ticks `ss_code` equals floor(k·(2^CW−1)/SS_TICKS). It reaches 2^CW−1 after SS_TICKS ticks and holds there.
- R4: `ipk_lim` is always the smaller of `ipk_cmd` and `ss_code`.
- R5: While `ovc_flag` is high (with `start_req` high), `ctl_rst` is 1 from the next edge and the switch stays off. One edge after the flag clears, `ctl_rst` is 0 and the ramp restarts from 0.
- R6: If `eamax_flag` is high without a break across SHORT_TICKS ticks, `ctl_rst` pulses high for exactly one cycle and the ramp restarts from 0. A single low cycle of the flag restarts the count.
- R7: When not in reset, `sw_drive` rises at the edge that samples `osc_tick`, unless the period is skipped.
- R8: A `pwm_trip` sampled in a cycle with no tick turns `sw_drive` off at that edge.
- R9: `sw_drive` stays high for at most MAXON = PERIOD_CLKS·3/4 consecutive cycles.
- R10: If `ipk_lim` < `skip_floor` at the tick, the switch stays off for that whole period. Equality does not skip.
- R11: `start_req` low takes priority over everything else: `ctl_rst` is 1 and `sw_drive` is 0 from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Level request to run the converter |
| osc_tick | input | 1 | One-cycle pulse at the start of each switching period |
| ovc_flag | input | 1 | Average-current overcurrent comparator |
| eamax_flag | input | 1 | Error amplifier at its maximum |
| pwm_trip | input | 1 | Peak-current PWM comparator trip |
| ipk_cmd | input | CW | Requested peak-current command |
| skip_floor | input | CW | Light-load skip threshold |
| ctl_rst | output | 1 | Controller reset |
| ss_code | output | CW | Soft-start ramp code |
| ipk_lim | output | CW | Clamped peak-current command |
| sw_drive | output | 1 | Gated switch drive |

## Verification
The bench walks the ramp tick by tick and compares each value against the floor formula, so a ramp that drifts through a remainder error or saturates early shows up at once. It also covers the following faults:
- A one-cycle break in the saturation flag must restart the short count. A timer that keeps counting across the break would reset too early, and a timer that is never cleared would trip at the wrong tick.
- The short reset must last exactly one cycle, which catches a stuck or missing restart.
- The overcurrent must hold reset for its whole duration.
- A trip must end the on-time at the exact cycle, and the untripped on-time must equal MAXON. An off-by-one counter changes both counts.
- A skip floor equal to the command must not skip, and a floor one above it must.

// File: rtl/dcdc_sup_pkg.sv
package dcdc_sup_pkg;
   typedef enum logic [1:0] {
      SUP_OFF    = 2'd0,
      SUP_HOLD   = 2'd1,
      SUP_ACTIVE = 2'd2
   } sup_state_t;
endpackage

// File: rtl/dcdc_ss_ramp.sv
module dcdc_ss_ramp #(
   parameter int CW       = 8,
   parameter int SS_TICKS = 3750
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          step,
   output logic [CW-1:0] code
);
   localparam int FULL = (1 << CW) - 1;
   localparam int QSTEP = FULL / SS_TICKS;
   localparam int RSTEP = FULL % SS_TICKS;
   localparam int TW = $clog2(SS_TICKS + 1);

   logic [TW-1:0] cnt_q;
   logic          done;
   logic          inc;

   assign done = (cnt_q == TW'(SS_TICKS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         code  <= '0;
      end else if (clr) begin
         cnt_q <= '0;
         code  <= '0;
      end else if (step && !done) begin
         cnt_q <= cnt_q + TW'(1);
         code  <= code + CW'(QSTEP) + {{(CW-1){1'b0}}, inc};
      end
   end

   generate
      if (RSTEP == 0) begin : g_exact
         assign inc = 1'b0;
      end else begin : g_frac
         logic [TW-1:0] rem_q;
         logic [TW:0]   rsum;
         assign rsum = {1'b0, rem_q} + (TW+1)'(RSTEP);
         assign inc  = (rsum >= (TW+1)'(SS_TICKS));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rem_q <= '0;
            end else if (clr) begin
               rem_q <= '0;
            end else if (step && !done) begin
               rem_q <= inc ? TW'(rsum - (TW+1)'(SS_TICKS)) : TW'(rsum);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/dcdc_short_timer.sv
module dcdc_short_timer #(
   parameter int SHORT_TICKS = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   input  logic active,
   input  logic tick,
   input  logic eamax,
   output logic trip
);
   localparam int SW = $clog2(SHORT_TICKS + 1);
   localparam logic [SW-1:0] LAST = SW'(SHORT_TICKS - 1);

   logic [SW-1:0] cnt_q;

   assign trip = active && eamax && tick && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr || !eamax) begin
         cnt_q <= '0;
      end else if (run && tick && (cnt_q != LAST)) begin
         cnt_q <= cnt_q + SW'(1);
      end
   end
endmodule

// File: rtl/dcdc_pwm_gate.sv
module dcdc_pwm_gate #(
   parameter int CW          = 8,
   parameter int PERIOD_CLKS = 500
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          en,
   input  logic          tick,
   input  logic          trip,
   input  logic [CW-1:0] ipk_lim,
   input  logic [CW-1:0] skip_floor,
   output logic          sw
);
   localparam int MAXON = (PERIOD_CLKS * 3) / 4;
   localparam int OW = $clog2(MAXON + 1);

   logic [OW-1:0] ocnt_q;
   logic          skip;

   assign skip = (ipk_lim < skip_floor);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw     <= 1'b0;
         ocnt_q <= '0;
      end else if (clr) begin
         sw     <= 1'b0;
         ocnt_q <= '0;
      end else if (tick) begin
         sw     <= en && !skip;
         ocnt_q <= OW'(1);
      end else if (sw) begin
         if (trip || (ocnt_q == OW'(MAXON))) begin
            sw <= 1'b0;
         end else begin
            ocnt_q <= ocnt_q + OW'(1);
         end
      end
   end
endmodule

// File: rtl/dcdc_supervisor.sv
module dcdc_supervisor
   import dcdc_sup_pkg::*;
#(
   parameter int CW          = 8,
   parameter int PERIOD_CLKS = 500,
   parameter int SS_TICKS    = 3750,
   parameter int SHORT_TICKS = 250
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_req,
   input  logic          osc_tick,
   input  logic          ovc_flag,
   input  logic          eamax_flag,
   input  logic          pwm_trip,
   input  logic [CW-1:0] ipk_cmd,
   input  logic [CW-1:0] skip_floor,
   output logic          ctl_rst,
   output logic [CW-1:0] ss_code,
   output logic [CW-1:0] ipk_lim,
   output logic          sw_drive
);
   generate
      if (CW < 2 || CW > 16) begin : g_bad_cw
         $error("dcdc_supervisor: CW out of range");
      end
      if (PERIOD_CLKS < 4) begin : g_bad_period
         $error("dcdc_supervisor: PERIOD_CLKS too small");
      end
      if (SS_TICKS < 1 || SHORT_TICKS < 1) begin : g_bad_ticks
         $error("dcdc_supervisor: tick counts must be positive");
      end
   endgenerate

   sup_state_t state_q, state_nxt;
   logic short_trip;
   logic active_q, active_nxt, run;

   assign active_q   = (state_q == SUP_ACTIVE);
   assign active_nxt = (state_nxt == SUP_ACTIVE);
   assign run        = active_q && active_nxt;

   always_comb begin
      if (!start_req)      state_nxt = SUP_OFF;
      else if (ovc_flag)   state_nxt = SUP_HOLD;
      else if (short_trip) state_nxt = SUP_HOLD;
      else                 state_nxt = SUP_ACTIVE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SUP_OFF;
      else        state_q <= state_nxt;
   end

   assign ctl_rst = !active_q;
   assign ipk_lim = (ipk_cmd < ss_code) ? ipk_cmd : ss_code;

   dcdc_ss_ramp #(.CW(CW), .SS_TICKS(SS_TICKS)) u_ramp (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!active_nxt),
      .step  (run && osc_tick),
      .code  (ss_code)
   );

   dcdc_short_timer #(.SHORT_TICKS(SHORT_TICKS)) u_short (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (!active_nxt),
      .run    (run),
      .active (active_q),
      .tick   (osc_tick),
      .eamax  (eamax_flag),
      .trip   (short_trip)
   );

   dcdc_pwm_gate #(.CW(CW), .PERIOD_CLKS(PERIOD_CLKS)) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (!active_nxt),
      .en         (run),
      .tick       (osc_tick),
      .trip       (pwm_trip),
      .ipk_lim    (ipk_lim),
      .skip_floor (skip_floor),
      .sw         (sw_drive)
   );
endmodule

// File: rtl/dcdc_sup_checker.sv
module dcdc_sup_checker #(
   parameter int CW          = 8,
   parameter int PERIOD_CLKS = 500
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_req,
   input logic          osc_tick,
   input logic          ovc_flag,
   input logic          pwm_trip,
   input logic [CW-1:0] ipk_cmd,
   input logic          ctl_rst,
   input logic [CW-1:0] ss_code,
   input logic [CW-1:0] ipk_lim,
   input logic          sw_drive
);
   localparam int MAXON = (PERIOD_CLKS * 3) / 4;

   int unsigned hi_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hi_cnt <= 0;
      else if (sw_drive) hi_cnt <= hi_cnt + 1;
      else               hi_cnt <= 0;
   end

   a_r5_ovc_reset: assert property (@(posedge clk) disable iff (!rst_n)
      start_req && ovc_flag |=> ctl_rst);
   a_r11_stop: assert property (@(posedge clk) disable iff (!rst_n)
      !start_req |=> ctl_rst && !sw_drive);
   a_r1_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rst |-> (ss_code == '0) && !sw_drive);
   a_r3_ramp_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_rst && $past(!ctl_rst) |-> ss_code >= $past(ss_code));
   a_r4_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      (ipk_lim <= ss_code) && (ipk_lim <= ipk_cmd));
   a_r7_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_drive) |-> $past(osc_tick));
   a_r8_trip_off: assert property (@(posedge clk) disable iff (!rst_n)
      sw_drive && pwm_trip && !osc_tick |=> !sw_drive);
   a_r9_duty_cap: assert property (@(posedge clk) disable iff (!rst_n)
      sw_drive |-> hi_cnt < MAXON);
endmodule

bind dcdc_supervisor dcdc_sup_checker #(.CW(CW), .PERIOD_CLKS(PERIOD_CLKS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_req (start_req),
   .osc_tick  (osc_tick),
   .ovc_flag  (ovc_flag),
   .pwm_trip  (pwm_trip),
   .ipk_cmd   (ipk_cmd),
   .ctl_rst   (ctl_rst),
   .ss_code   (ss_code),
   .ipk_lim   (ipk_lim),
   .sw_drive  (sw_drive)
);

// File: tb/tb_dcdc_supervisor.sv
module tb_dcdc_supervisor;
   localparam int CW = 8;
   localparam int PER = 20;
   localparam int SS = 16;
   localparam int SHT = 8;
   localparam int MAXON = (PER * 3) / 4;
   localparam int FULL = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_req = 1'b0, osc_tick = 1'b0, ovc_flag = 1'b0;
   logic eamax_flag = 1'b0, pwm_trip = 1'b0;
   logic [CW-1:0] ipk_cmd = '1, skip_floor = '0;
   logic ctl_rst, sw_drive;
   logic [CW-1:0] ss_code, ipk_lim;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dcdc_supervisor #(.CW(CW), .PERIOD_CLKS(PER), .SS_TICKS(SS), .SHORT_TICKS(SHT)) dut (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .osc_tick(osc_tick),
      .ovc_flag(ovc_flag), .eamax_flag(eamax_flag), .pwm_trip(pwm_trip),
      .ipk_cmd(ipk_cmd), .skip_floor(skip_floor), .ctl_rst(ctl_rst),
      .ss_code(ss_code), .ipk_lim(ipk_lim), .sw_drive(sw_drive));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // one switching period, starting and ending at a falling edge
   task automatic run_period(input int trip_at, output int on_n, output int rst_cnt);
      on_n = 0; rst_cnt = 0;
      for (int j = 0; j < PER; j++) begin
         osc_tick = (j == 0);
         pwm_trip = (trip_at != 0) && (j == trip_at);
         @(negedge clk);
         if (sw_drive) on_n++;
         if (ctl_rst) rst_cnt++;
      end
      osc_tick = 1'b0; pwm_trip = 1'b0;
   endtask

   task automatic t_reset_state();
      int on_n, rc;
      chk("R1 ctl_rst in reset", int'(ctl_rst), 1);
      chk("R1 ss_code in reset", int'(ss_code), 0);
      rst_n = 1'b1;
      @(negedge clk);
      run_period(0, on_n, rc);
      chk("R1 no switching while idle", on_n, 0);
      chk("R1 reset held while idle", rc, PER);
   endtask

   task automatic t_ramp();
      int on_n, rc;
      start_req = 1'b1;
      @(negedge clk);
      chk("R2 reset released", int'(ctl_rst), 0);
      chk("R2 ramp starts at zero", int'(ss_code), 0);
      for (int k = 1; k <= SS + 2; k++) begin
         run_period(0, on_n, rc);
         chk($sformatf("R3 ramp after %0d ticks", k), int'(ss_code),
             (k >= SS) ? FULL : (k * FULL) / SS);
         if (k == 3) begin
            chk("R4 clamp follows ramp", int'(ipk_lim), (3 * FULL) / SS);
            chk("R9 untripped on-time", on_n, MAXON);
         end
      end
      ipk_cmd = 8'd100;
      #1;
      chk("R4 clamp follows command", int'(ipk_lim), 100);
   endtask

   task automatic t_trip_and_skip();
      int on_n, rc;
      run_period(5, on_n, rc);
      chk("R8 trip ends on-time", on_n, 5);
      run_period(1, on_n, rc);
      chk("R8 earliest trip", on_n, 1);
      run_period(18, on_n, rc);
      chk("R9 late trip capped by duty", on_n, MAXON);
      skip_floor = 8'd101;
      run_period(0, on_n, rc);
      chk("R10 floor above command skips", on_n, 0);
      skip_floor = 8'd100;
      run_period(0, on_n, rc);
      chk("R10 equal floor does not skip", on_n, MAXON);
      chk("R7 turn-on resumed", int'(on_n > 0), 1);
      skip_floor = '0;
   endtask

   task automatic t_overcurrent();
      int on_n, rc;
      ovc_flag = 1'b1;
      @(negedge clk);
      chk("R5 reset on overcurrent", int'(ctl_rst), 1);
      chk("R5 ramp cleared", int'(ss_code), 0);
      chk("R5 switch off", int'(sw_drive), 0);
      run_period(0, on_n, rc);
      run_period(0, on_n, rc);
      chk("R5 reset held through flag", rc, PER);
      chk("R5 no switching in overcurrent", on_n, 0);
      ovc_flag = 1'b0;
      @(negedge clk);
      chk("R5 reset released after flag", int'(ctl_rst), 0);
      chk("R5 ramp restarts at zero", int'(ss_code), 0);
      run_period(0, on_n, rc);
      chk("R5 ramp first step", int'(ss_code), FULL / SS);
   endtask

   task automatic t_short();
      int on_n, rc, rtot;
      for (int k = 0; k < SS; k++) run_period(0, on_n, rc);
      eamax_flag = 1'b1;
      rtot = 0;
      for (int k = 0; k < SHT - 1; k++) begin
         run_period(0, on_n, rc);
         rtot += rc;
      end
      eamax_flag = 1'b0;
      @(negedge clk);
      eamax_flag = 1'b1;
      for (int k = 0; k < SHT - 1; k++) begin
         run_period(0, on_n, rc);
         rtot += rc;
      end
      chk("R6 break in flag restarts count", rtot, 0);
      chk("R6 ramp untouched before trip", int'(ss_code), FULL);
      run_period(0, on_n, rc);
      chk("R6 one-cycle reset on short", rc, 1);
      chk("R6 ramp restarted", int'(ss_code), 0);
      chk("R6 no switching on trip period", on_n, 0);
      eamax_flag = 1'b0;
      run_period(0, on_n, rc);
      chk("R6 soft start reruns", int'(ss_code), FULL / SS);
   endtask

   task automatic t_stop();
      int on_n, rc;
      start_req = 1'b0;
      @(negedge clk);
      chk("R11 reset on stop", int'(ctl_rst), 1);
      chk("R11 switch off on stop", int'(sw_drive), 0);
      run_period(0, on_n, rc);
      chk("R11 no switching after stop", on_n, 0);
      chk("R11 ramp cleared after stop", int'(ss_code), 0);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset_state();
      t_ramp();
      t_trip_and_skip();
      t_overcurrent();
      t_short();
      t_stop();
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         finish_run();
      end
   end
endmodule